// File: doc/BRIEF.md
# Interpolating TDC Timestamp Encoder

The encoder turns a hit into a fine-grained arrival time. The time is built from four nested resolution levels. The coarsest is a free-running count of the reference clock, with a 25 ns step. Below it sits the phase of a clock running at eight times the reference, given as 3 bits at 3.125 ns per step. Next comes the edge position inside a circular 32-cell delay-line snapshot, given as 5 bits at about 98 ps per step. The finest level is an optional 2-bit interpolation field that splits each delay cell into quarters, for about 25 ps. The multiplied clock, the delay line and the interpolator all sit outside the block. Their sampled states arrive as inputs together with the hit strobe.

A hit strobe captures the snapshot, the phase, the interpolation bits, the mode and the current coarse count. On the next cycle the snapshot is cleaned by a majority-of-three filter over circularly adjacent taps. The first falling transition is then located and encoded, and the assembled word is registered. Each hit gives exactly one result strobe, two cycles after the hit, whatever the spacing between hits. A separate one-cycle marker reports each wrap of the coarse count, so that downstream logic can extend the time beyond the count's width. In low-resolution mode the word keeps its layout and the interpolation field reads zero.

Top module: `tdc_stamp_encoder`

## Requirements
- R1: While reset is asserted and after its release until the first hit result, ts_vld_o, ts_err_o, rollover_o and ts_o are all zero.
- R2: A hit_i sampled high at clock edge k produces ts_vld_o high for exactly the cycle following edge k+1. Every hit gives its own strobe, including hits on consecutive cycles, and no strobe appears without a hit.
- R3: The coarse count is zero after reset and increments on every clock edge modulo 2^COARSE_W. The value at the capturing edge appears in ts_o[17:10].
- R4: rollover_o is high for exactly one cycle, the cycle in which the coarse count has just wrapped from its maximum to zero, and is low at all other times.
- R5: Tap 0 is the first delay cell and taps are treated as a ring. The field ts_o[6:2] holds the index i of the 1 that precedes the first 1-to-0 step found scanning i upward, where a step means filtered tap i is 1 and filtered tap (i+1) mod 32 is 0. A run of ones that ends at tap 31 with tap 0 low encodes as 31.
- R6: Each filtered tap is the majority of raw taps i-1, i and i+1 taken around the ring, so a single flipped tap inside a run of ones or of zeros does not change the code.
- R7: When the filtered snapshot holds several 1-to-0 steps, the step with the lowest index i decides the code.
- R8: A snapshot whose filtered form has no 1-to-0 step, such as all ones or all zeros, gives ts_err_o high with its strobe, and ts_o[6:2] then reads zero. Otherwise ts_err_o is low.
- R9: With hires_i high at capture, ts_o[1:0] carries the interpolation input. With hires_i low, ts_o[1:0] is zero.
- R10: ts_o[9:7] carries the phase input sampled at the capturing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one coarse step per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | 1 | Hit strobe, one cycle per hit |
| taps_i | input | 32 | Sampled delay-line snapshot, bit 0 is the first cell |
| phase_i | input | 3 | Sampled phase of the multiplied clock |
| interp_i | input | 2 | Sampled interpolation sub-bin |
| hires_i | input | 1 | 1 selects high-resolution mode |
| ts_vld_o | output | 1 | Result strobe |
| ts_o | output | 18 | {coarse[7:0], phase[2:0], tap[4:0], interp[1:0]} |
| ts_err_o | output | 1 | No transition found in the snapshot |
| rollover_o | output | 1 | One-cycle coarse wrap marker |

## Verification
Two situations are hard to reach from the ports. One is a hit captured right at the coarse wrap while other hits are still in flight, with the rollover marker expected in the same window. The other is a snapshot that holds more than one falling step after filtering. The stimulus runs long enough to pass several wraps and places directed hits at counts 255 and 0. It also builds ring patterns that wrap past tap 31, carry single bubbles, or hold two separate runs of ones, and mixes these with random patterns on back-to-back and spaced hits in both modes.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

  typedef enum logic {
    RES_LOW  = 1'b0,
    RES_HIGH = 1'b1
  } res_mode_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/tdc_coarse_counter.sv
module tdc_coarse_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap_q, wrap_d;

  always_comb begin
    cnt_d  = cnt_q;
    wrap_d = 1'b0;
    if (cnt_en_i) begin
      cnt_d  = cnt_q + 1'b1;
      wrap_d = (cnt_q == CNT_MAX);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wrap_q <= wrap_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap_q;

endmodule

// File: rtl/tdc_bubble_filter.sv
module tdc_bubble_filter #(
  parameter int unsigned N_TAPS = 32
) (
  input  logic [N_TAPS-1:0] raw_i,
  output logic [N_TAPS-1:0] clean_o
);

  for (genvar g = 0; g < N_TAPS; g++) begin : g_vote
    localparam int unsigned PREV = (g + N_TAPS - 1) % N_TAPS;
    localparam int unsigned NEXT = (g + 1) % N_TAPS;
    assign clean_o[g] = tdc_pkg::vote3(raw_i[PREV], raw_i[g], raw_i[NEXT]);
  end

endmodule

// File: rtl/tdc_edge_encoder.sv
module tdc_edge_encoder #(
  parameter int unsigned N_TAPS = 32,
  localparam int unsigned CODE_W = $clog2(N_TAPS)
) (
  input  logic [N_TAPS-1:0] therm_i,
  output logic [CODE_W-1:0] code_o,
  output logic              none_o
);

  logic [N_TAPS-1:0] step;

  for (genvar g = 0; g < N_TAPS; g++) begin : g_step
    localparam int unsigned NEXT = (g + 1) % N_TAPS;
    assign step[g] = therm_i[g] & ~therm_i[NEXT];
  end

  // Scan downward so the lowest index is the last to write.
  always_comb begin
    code_o = '0;
    for (int i = N_TAPS - 1; i >= 0; i--) begin
      if (step[i]) code_o = CODE_W'(i);
    end
    none_o = ~|step;
  end

endmodule

// File: rtl/tdc_stamp_encoder.sv
module tdc_stamp_encoder #(
  parameter int unsigned TAPS     = 32,
  parameter int unsigned PHASE_W  = 3,
  parameter int unsigned INTERP_W = 2,
  parameter int unsigned COARSE_W = 8,
  localparam int unsigned TAP_W   = $clog2(TAPS),
  localparam int unsigned TS_W    = COARSE_W + PHASE_W + TAP_W + INTERP_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hit_i,
  input  logic [TAPS-1:0]     taps_i,
  input  logic [PHASE_W-1:0]  phase_i,
  input  logic [INTERP_W-1:0] interp_i,
  input  logic                hires_i,
  output logic                ts_vld_o,
  output logic [TS_W-1:0]     ts_o,
  output logic                ts_err_o,
  output logic                rollover_o
);

  import tdc_pkg::*;

  // Coarse time base
  logic [COARSE_W-1:0] coarse_cnt;

  tdc_coarse_counter #(.CNT_W(COARSE_W)) u_coarse (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en_i (1'b1),
    .cnt_o    (coarse_cnt),
    .wrap_o   (rollover_o)
  );

  // Stage 1: capture on hit
  logic                cap_vld_q, cap_vld_d;
  logic [TAPS-1:0]     cap_taps_q, cap_taps_d;
  logic [PHASE_W-1:0]  cap_phase_q, cap_phase_d;
  logic [INTERP_W-1:0] cap_interp_q, cap_interp_d;
  res_mode_e           cap_mode_q, cap_mode_d;
  logic [COARSE_W-1:0] cap_coarse_q, cap_coarse_d;

  always_comb begin
    cap_vld_d    = hit_i;
    cap_taps_d   = cap_taps_q;
    cap_phase_d  = cap_phase_q;
    cap_interp_d = cap_interp_q;
    cap_mode_d   = cap_mode_q;
    cap_coarse_d = cap_coarse_q;
    if (hit_i) begin
      cap_taps_d   = taps_i;
      cap_phase_d  = phase_i;
      cap_interp_d = interp_i;
      cap_mode_d   = hires_i ? RES_HIGH : RES_LOW;
      cap_coarse_d = coarse_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_vld_q    <= 1'b0;
      cap_taps_q   <= '0;
      cap_phase_q  <= '0;
      cap_interp_q <= '0;
      cap_mode_q   <= RES_LOW;
      cap_coarse_q <= '0;
    end else begin
      cap_vld_q    <= cap_vld_d;
      cap_taps_q   <= cap_taps_d;
      cap_phase_q  <= cap_phase_d;
      cap_interp_q <= cap_interp_d;
      cap_mode_q   <= cap_mode_d;
      cap_coarse_q <= cap_coarse_d;
    end
  end

  // Stage 2: clean, encode, assemble
  logic [TAPS-1:0]  clean_taps;
  logic [TAP_W-1:0] tap_code;
  logic             no_edge;

  tdc_bubble_filter #(.N_TAPS(TAPS)) u_filter (
    .raw_i   (cap_taps_q),
    .clean_o (clean_taps)
  );

  tdc_edge_encoder #(.N_TAPS(TAPS)) u_encode (
    .therm_i (clean_taps),
    .code_o  (tap_code),
    .none_o  (no_edge)
  );

  logic [INTERP_W-1:0] fine_field;
  logic [TAP_W-1:0]    tap_field;

  if (INTERP_W > 0) begin : g_fine
    assign fine_field = (cap_mode_q == RES_HIGH) ? cap_interp_q : '0;
  end else begin : g_no_fine
    assign fine_field = '0;
  end

  assign tap_field = no_edge ? '0 : tap_code;

  logic            out_vld_q, out_vld_d;
  logic [TS_W-1:0] out_ts_q, out_ts_d;
  logic            out_err_q, out_err_d;

  always_comb begin
    out_vld_d = cap_vld_q;
    out_ts_d  = out_ts_q;
    out_err_d = out_err_q;
    if (cap_vld_q) begin
      out_ts_d  = {cap_coarse_q, cap_phase_q, tap_field, fine_field};
      out_err_d = no_edge;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld_q <= 1'b0;
      out_ts_q  <= '0;
      out_err_q <= 1'b0;
    end else begin
      out_vld_q <= out_vld_d;
      out_ts_q  <= out_ts_d;
      out_err_q <= out_err_d;
    end
  end

  assign ts_vld_o = out_vld_q;
  assign ts_o     = out_ts_q;
  assign ts_err_o = out_err_q & out_vld_q;

endmodule

// File: rtl/tdc_stamp_checker.sv
module tdc_stamp_checker #(
  parameter int unsigned PHASE_W  = 3,
  parameter int unsigned INTERP_W = 2,
  parameter int unsigned TAP_W    = 5,
  parameter int unsigned COARSE_W = 8,
  parameter int unsigned TS_W     = 18
) (
  input logic                clk,
  input logic                rst_n,
  input logic                hit_i,
  input logic                hires_i,
  input logic [PHASE_W-1:0]  phase_i,
  input logic                ts_vld_o,
  input logic [TS_W-1:0]     ts_o,
  input logic                ts_err_o,
  input logic                rollover_o,
  input logic [COARSE_W-1:0] coarse_cnt
);

  localparam int unsigned TAP_LSB   = INTERP_W;
  localparam int unsigned PHASE_LSB = INTERP_W + TAP_W;

  AST_HIT_GIVES_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |-> ##2 ts_vld_o); // R2

  AST_STROBE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    ts_vld_o |-> $past(hit_i, 2)); // R2

  AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rollover_o |-> (coarse_cnt == '0)); // R4

  AST_WRAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rollover_o |=> !rollover_o); // R4

  AST_ERR_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ts_err_o |-> ts_vld_o); // R8

  AST_ERR_TAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ts_err_o |-> (ts_o[TAP_LSB +: TAP_W] == '0)); // R8

  AST_LOWRES_FINE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_vld_o && !$past(hires_i, 2)) |-> (ts_o[INTERP_W-1:0] == '0)); // R9

  AST_PHASE_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
    ts_vld_o |-> (ts_o[PHASE_LSB +: PHASE_W] == $past(phase_i, 2))); // R10

endmodule

bind tdc_stamp_encoder tdc_stamp_checker #(
  .PHASE_W  (PHASE_W),
  .INTERP_W (INTERP_W),
  .TAP_W    (TAP_W),
  .COARSE_W (COARSE_W),
  .TS_W     (TS_W)
) u_stamp_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .hit_i      (hit_i),
  .hires_i    (hires_i),
  .phase_i    (phase_i),
  .ts_vld_o   (ts_vld_o),
  .ts_o       (ts_o),
  .ts_err_o   (ts_err_o),
  .rollover_o (rollover_o),
  .coarse_cnt (coarse_cnt)
);

// File: tb/test_tdc_stamp_encoder.sv
module test_tdc_stamp_encoder;

  logic        clk;
  logic        rst_n;
  logic        hit_i;
  logic [31:0] taps_i;
  logic [2:0]  phase_i;
  logic [1:0]  interp_i;
  logic        hires_i;
  logic        ts_vld_o;
  logic [17:0] ts_o;
  logic        ts_err_o;
  logic        rollover_o;

  tdc_stamp_encoder i_tdc_stamp_encoder (
    .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .taps_i(taps_i),
    .phase_i(phase_i), .interp_i(interp_i), .hires_i(hires_i),
    .ts_vld_o(ts_vld_o), .ts_o(ts_o), .ts_err_o(ts_err_o),
    .rollover_o(rollover_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  int edges  = 0;
  bit done   = 0;

  typedef struct {
    int          due;
    logic [17:0] word;
    logic        err;
    string       tag;
  } exp_t;
  exp_t q[$];

  always @(posedge clk or negedge rst_n)
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at edge %0d", req, act, exp, edges);
    end
  endtask

  // Reference: ring majority filter, then lowest falling step.
  function automatic logic [5:0] ref_code(input logic [31:0] t);
    logic [31:0] f;
    for (int i = 0; i < 32; i++)
      f[i] = (t[(i+31)%32] + t[i] + t[(i+1)%32]) >= 2;
    for (int i = 0; i < 32; i++)
      if (f[i] && !f[(i+1)%32]) return {1'b0, 5'(i)};
    return 6'h20;
  endfunction

  task automatic send(input logic [31:0] t, input logic [2:0] ph, input logic [1:0] fi,
                      input logic hr, input string tag);
    exp_t e;
    logic [5:0] c;
    @(negedge clk);
    hit_i = 1'b1; taps_i = t; phase_i = ph; interp_i = fi; hires_i = hr;
    c = ref_code(t);
    e.due  = edges + 2;
    e.err  = c[5];
    e.word = {8'(edges % 256), ph, c[5] ? 5'd0 : c[4:0], hr ? fi : 2'b00};
    e.tag  = tag;
    q.push_back(e);
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hit_i = 1'b0;
      taps_i = $urandom;
    end
  endtask

  function automatic logic [31:0] ring_run(input int start, input int len);
    logic [31:0] v = '0;
    for (int i = 0; i < len; i++) v[(start + i) % 32] = 1'b1;
    return v;
  endfunction

  // Monitor: strobe timing, word, error flag, wrap marker
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (q.size() > 0 && q[0].due == edges) begin
        check(ts_vld_o == 1'b1, {"R2 strobe ", q[0].tag}, ts_vld_o, 1);
        check(ts_o == q[0].word, {"R3/R5/R9/R10 word ", q[0].tag}, ts_o, q[0].word);
        check(ts_err_o == q[0].err, {"R8 err ", q[0].tag}, ts_err_o, q[0].err);
        void'(q.pop_front());
      end else if (ts_vld_o) begin
        check(1'b0, "R2 spurious strobe", ts_vld_o, 0);
      end
      if (edges % 256 <= 1 || rollover_o)
        check(rollover_o == (edges > 0 && edges % 256 == 0), "R4 rollover", rollover_o,
              (edges > 0 && edges % 256 == 0));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; hit_i = 1'b0; taps_i = '0; phase_i = '0; interp_i = '0; hires_i = 1'b0;
    repeat (3) @(negedge clk);
    check({ts_vld_o, ts_err_o, rollover_o, ts_o} == '0, "R1 reset outputs",
          {ts_vld_o, ts_err_o, rollover_o, ts_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({ts_vld_o, ts_err_o, rollover_o, ts_o} == '0, "R1 idle after reset",
          {ts_vld_o, ts_err_o, rollover_o, ts_o}, 0);

    // R5 clean thermometers, including ring wrap and end at tap 31
    send(ring_run(0, 10),  3'd5, 2'd2, 1'b1, "R5 run 0..9");       gap(2);
    send(ring_run(20, 16), 3'd1, 2'd1, 1'b1, "R5 ring 20..3");     gap(1);
    send(ring_run(10, 22), 3'd7, 2'd3, 1'b1, "R5 end at 31");      gap(3);
    // R6 bubbles
    send(ring_run(0, 16) & ~32'h80, 3'd2, 2'd0, 1'b1, "R6 zero bubble"); gap(1);
    send(ring_run(0, 16) | (32'h1 << 25), 3'd4, 2'd1, 1'b1, "R6 one bubble"); gap(1);
    // R7 two runs
    send(ring_run(2, 4) | ring_run(20, 5), 3'd6, 2'd2, 1'b1, "R7 two runs"); gap(1);
    // R8 no edge
    send(32'hFFFF_FFFF, 3'd3, 2'd3, 1'b1, "R8 all ones");
    send(32'h0000_0000, 3'd0, 2'd1, 1'b0, "R8 all zeros");
    send(32'h0000_0020, 3'd1, 2'd2, 1'b1, "R8 lone one");          gap(2);
    // R9 low resolution drops interpolation
    send(ring_run(5, 8), 3'd2, 2'd3, 1'b0, "R9 low res");          gap(1);
    // R2 back-to-back hits
    send(ring_run(1, 3), 3'd0, 2'd0, 1'b1, "R2 b2b a");
    send(ring_run(7, 9), 3'd1, 2'd1, 1'b1, "R2 b2b b");
    send(ring_run(30, 4), 3'd2, 2'd2, 1'b0, "R2 b2b c");           gap(2);

    // R3/R4 hits around the coarse wrap
    while (edges % 256 != 254) gap(1);
    send(ring_run(3, 6), 3'd5, 2'd1, 1'b1, "R3 count 255");
    send(ring_run(9, 6), 3'd6, 2'd2, 1'b1, "R3 count 0");          gap(3);

    // Random mix
    for (int k = 0; k < 700; k++) begin
      logic [31:0] t;
      int sel = $urandom_range(0, 3);
      if (sel == 0)      t = $urandom;
      else begin
        t = ring_run($urandom_range(0, 31), $urandom_range(2, 30));
        if (sel == 1) t[$urandom_range(0, 31)] ^= 1'b1;
      end
      send(t, 3'($urandom), 2'($urandom), 1'($urandom), "R5 random");
      gap($urandom_range(0, 2));
    end
    gap(4);
    check(q.size() == 0, "R2 all strobes seen", q.size(), 0);
    finish_run();
  end

endmodule